// File: doc/BRIEF.md
# Packet-Mapped Register File for a Command Microcontroller

This block is the register file of a small microcontroller that parses a command packet stream. It holds 32 registers of 32 bits. The datapath reaches them through two combinational read ports and one synchronous write port. Most addresses are plain storage. A few are wired to live packet state:

- Address 0x00 is a constant zero.
- Address 0x1c shows how many dwords remain in the current packet.
- Addresses 0x1d and 0x1e are two address ports.
- Address 0x1f is the data port. Reading it takes the next dword from the incoming stream. Writing it sends a dword out.

Writing the header register (0x01) stores the header and loads the remaining count from the header's count field. It also looks up the handler address for the header's opcode in a 128-entry jump table and raises a dispatch request one cycle later. The jump table is filled through a load port before packets start.

The stream arrives on a valid/ready handshake. A data-port read while no dword is offered raises a stall flag, and the datapath holds the read until the stream catches up.

Top module: `mcu_pkt_regfile`

## Requirements
- R1: A read of address 0x00 on either port returns zero, and a write to address 0x00 has no effect on what it reads back.
- R2: A write to a storage address (0x01 to 0x1b, 0x1d, 0x1e) is visible on both read ports from the cycle after the write edge. A read in the same cycle as the write returns the old value.
- R3: A write to address 0x01 loads the remaining count from header bits [13:0]. Address 0x1c reads that count, zero-extended, from the next cycle.
- R4: A header write whose opcode field (bits [23:16]) is below 128 raises dispValid for exactly one cycle, in the cycle after the write. In that cycle dispOpcode is bits [22:16] and dispAddr is the jump-table entry at that opcode.
- R5: A header write whose opcode field is 128 or more raises dispBad instead of dispValid, for one cycle. The count is still loaded.
- R6: A data-port read (read enable high, address 0x1f) while pktValid is high returns pktData in the same cycle and drives pktReady high. The remaining count drops by one at the next edge and stays at zero when already zero. With read enable low, nothing is taken.
- R7: A data-port read while pktValid is low drives rdStall high and pktReady low, and leaves the count unchanged.
- R8: When both read ports read address 0x1f in the same cycle, exactly one dword is taken. Both ports return it.
- R9: A write to 0x1f puts the word on outWord with outValid high for the next cycle only. Writes to 0x1d and 0x1e drive addrPortA and addrPortB from the next cycle.
- R10: A write to 0x1c overwrites the count. A header write or a 0x1c write takes precedence over a data-port read made in the same cycle.
- R11: After reset all storage reads zero, the count is zero, and dispValid, dispBad and outValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEnA | input | 1 | Read enable, port A (needed for a data-port pop) |
| rdAddrA | input | 5 | Read address, port A |
| rdDataA | output | 32 | Read data, port A |
| rdEnB | input | 1 | Read enable, port B |
| rdAddrB | input | 5 | Read address, port B |
| rdDataB | output | 32 | Read data, port B |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Write address |
| wrData | input | 32 | Write data |
| pktValid | input | 1 | Stream dword offered |
| pktData | input | 32 | Stream dword |
| pktReady | output | 1 | Stream dword taken this cycle |
| rdStall | output | 1 | Data-port read waiting for a dword |
| tblWe | input | 1 | Jump-table entry write |
| tblIdx | input | 7 | Jump-table entry index |
| tblAddr | input | 12 | Handler address to store |
| dispValid | output | 1 | Dispatch request |
| dispAddr | output | 12 | Handler address of the dispatch |
| dispOpcode | output | 7 | Opcode of the dispatch |
| dispBad | output | 1 | Header opcode out of range |
| outValid | output | 1 | Outgoing data word valid |
| outWord | output | 32 | Outgoing data word |
| addrPortA | output | 32 | First address port value |
| addrPortB | output | 32 | Second address port value |

## Verification
Read data, pktReady and rdStall are combinational. The bench samples them one nanosecond after it drives the inputs, in the same cycle. The count, stored values, address ports and the outgoing word are registered. The bench samples them just after the edge that follows the stimulus. Dispatch results are due one cycle after the header write. The driver pushes each expected dispatch into a queue when it issues the write, and a monitor on the falling edge pops and compares every dispValid or dispBad pulse. Any pulse with no queued entry, and any entry left over at the end, counts as a failure.

// File: rtl/mrf_pkg.sv
package mrf_pkg;
  localparam int REG_AW = 5;
  localparam logic [REG_AW-1:0] REG_ZERO = 5'h00;
  localparam logic [REG_AW-1:0] REG_HDR  = 5'h01;
  localparam logic [REG_AW-1:0] REG_CNT  = 5'h1c;
  localparam logic [REG_AW-1:0] REG_ADRA = 5'h1d;
  localparam logic [REG_AW-1:0] REG_ADRB = 5'h1e;
  localparam logic [REG_AW-1:0] REG_DATA = 5'h1f;

  typedef struct packed {
    logic popData;
    logic loadHdr;
    logic wrCount;
    logic wrStore;
    logic emitOut;
  } mrfStrobes_t;
endpackage

// File: rtl/mrf_ctrl.sv
module mrf_ctrl
  import mrf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEnA,
  input  logic [REG_AW-1:0] rdAddrA,
  input  logic              rdEnB,
  input  logic [REG_AW-1:0] rdAddrB,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic              pktValid,
  output mrfStrobes_t       strb,
  output logic              pktReady,
  output logic              rdStall
);
  logic dataRead;

  always_comb begin
    dataRead      = (rdEnA && rdAddrA == REG_DATA) || (rdEnB && rdAddrB == REG_DATA);
    strb.popData  = dataRead && pktValid;
    strb.loadHdr  = wrEn && wrAddr == REG_HDR;
    strb.wrCount  = wrEn && wrAddr == REG_CNT;
    strb.emitOut  = wrEn && wrAddr == REG_DATA;
    strb.wrStore  = wrEn && wrAddr != REG_ZERO && wrAddr != REG_CNT && wrAddr != REG_DATA;
    pktReady      = strb.popData;
    rdStall       = dataRead && !pktValid;
  end

  assert_stall_no_pop_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdStall |-> !pktReady);
  assert_pop_needs_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    pktReady |-> pktValid);
  assert_one_write_kind_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadHdr, strb.wrCount, strb.emitOut}));
endmodule

// File: rtl/mrf_datapath.sv
module mrf_datapath
  import mrf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 14,
  parameter int OPC_W   = 7,
  parameter int OPC_LSB = 16,
  parameter int JADDR_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  mrfStrobes_t        strb,
  input  logic [REG_AW-1:0]  rdAddrA,
  input  logic [REG_AW-1:0]  rdAddrB,
  input  logic [REG_AW-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [DATA_W-1:0]  pktData,
  input  logic               tblWe,
  input  logic [OPC_W-1:0]   tblIdx,
  input  logic [JADDR_W-1:0] tblAddr,
  output logic [DATA_W-1:0]  rdDataA,
  output logic [DATA_W-1:0]  rdDataB,
  output logic               dispValid,
  output logic [JADDR_W-1:0] dispAddr,
  output logic [OPC_W-1:0]   dispOpcode,
  output logic               dispBad,
  output logic               outValid,
  output logic [DATA_W-1:0]  outWord,
  output logic [DATA_W-1:0]  addrPortA,
  output logic [DATA_W-1:0]  addrPortB
);
  localparam int NUM_REGS = 1 << REG_AW;
  localparam int NUM_OPC  = 1 << OPC_W;

  logic [DATA_W-1:0]  regs    [NUM_REGS];
  logic [JADDR_W-1:0] jumpTbl [NUM_OPC];
  logic [CNT_W-1:0]   count;
  logic [OPC_W-1:0]   hdrOpc;
  logic               hdrOk;

  assign hdrOpc = wrData[OPC_LSB +: OPC_W];
  assign hdrOk  = !wrData[OPC_LSB + OPC_W];

  function automatic logic [DATA_W-1:0] readReg(input logic [REG_AW-1:0] a);
    case (a)
      REG_ZERO: readReg = '0;
      REG_CNT:  readReg = DATA_W'(count);
      REG_DATA: readReg = pktData;
      default:  readReg = regs[a];
    endcase
  endfunction

  assign rdDataA   = readReg(rdAddrA);
  assign rdDataB   = readReg(rdAddrB);
  assign addrPortA = regs[REG_ADRA];
  assign addrPortB = regs[REG_ADRB];

  always_ff @(posedge clk) begin
    if (tblWe) jumpTbl[tblIdx] <= tblAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (strb.wrStore) begin
      regs[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                           count <= '0;
    else if (strb.loadHdr)               count <= wrData[CNT_W-1:0];
    else if (strb.wrCount)               count <= wrData[CNT_W-1:0];
    else if (strb.popData && count != 0) count <= count - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dispValid  <= 1'b0;
      dispBad    <= 1'b0;
      dispAddr   <= '0;
      dispOpcode <= '0;
      outValid   <= 1'b0;
      outWord    <= '0;
    end else begin
      dispValid <= strb.loadHdr && hdrOk;
      dispBad   <= strb.loadHdr && !hdrOk;
      if (strb.loadHdr) begin
        dispOpcode <= hdrOpc;
        dispAddr   <= jumpTbl[hdrOpc];
      end
      outValid <= strb.emitOut;
      if (strb.emitOut) outWord <= wrData;
    end
  end

  assert_zero_read_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == REG_ZERO) |-> (rdDataA == '0));
  assert_count_dec_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.popData && !strb.loadHdr && !strb.wrCount && count != 0)
      |=> (count == $past(count) - CNT_W'(1)));
  assert_count_sat_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.popData && !strb.loadHdr && !strb.wrCount && count == 0) |=> (count == 0));
  assert_disp_after_hdr_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadHdr |=> (dispValid || dispBad));
  assert_disp_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dispValid, dispBad}));
  assert_out_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.emitOut |=> !outValid);
endmodule

// File: rtl/mcu_pkt_regfile.sv
module mcu_pkt_regfile
  import mrf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 14,
  parameter int OPC_W   = 7,
  parameter int OPC_LSB = 16,
  parameter int JADDR_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdEnA,
  input  logic [REG_AW-1:0]  rdAddrA,
  output logic [DATA_W-1:0]  rdDataA,
  input  logic               rdEnB,
  input  logic [REG_AW-1:0]  rdAddrB,
  output logic [DATA_W-1:0]  rdDataB,
  input  logic               wrEn,
  input  logic [REG_AW-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               pktValid,
  input  logic [DATA_W-1:0]  pktData,
  output logic               pktReady,
  output logic               rdStall,
  input  logic               tblWe,
  input  logic [OPC_W-1:0]   tblIdx,
  input  logic [JADDR_W-1:0] tblAddr,
  output logic               dispValid,
  output logic [JADDR_W-1:0] dispAddr,
  output logic [OPC_W-1:0]   dispOpcode,
  output logic               dispBad,
  output logic               outValid,
  output logic [DATA_W-1:0]  outWord,
  output logic [DATA_W-1:0]  addrPortA,
  output logic [DATA_W-1:0]  addrPortB
);
  mrfStrobes_t strb;

  mrf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .rdEnA(rdEnA), .rdAddrA(rdAddrA), .rdEnB(rdEnB), .rdAddrB(rdAddrB),
    .wrEn(wrEn), .wrAddr(wrAddr), .pktValid(pktValid),
    .strb(strb), .pktReady(pktReady), .rdStall(rdStall)
  );

  mrf_datapath #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .OPC_W(OPC_W),
    .OPC_LSB(OPC_LSB), .JADDR_W(JADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .wrAddr(wrAddr), .wrData(wrData),
    .pktData(pktData), .tblWe(tblWe), .tblIdx(tblIdx), .tblAddr(tblAddr),
    .rdDataA(rdDataA), .rdDataB(rdDataB),
    .dispValid(dispValid), .dispAddr(dispAddr), .dispOpcode(dispOpcode),
    .dispBad(dispBad), .outValid(outValid), .outWord(outWord),
    .addrPortA(addrPortA), .addrPortB(addrPortB)
  );
endmodule

// File: tb/mcu_pkt_regfile_tb.sv
module mcu_pkt_regfile_tb;
  logic clk = 0, rstN = 0;
  logic rdEnA = 0, rdEnB = 0, wrEn = 0, pktValid = 0, tblWe = 0;
  logic [4:0] rdAddrA = 0, rdAddrB = 0, wrAddr = 0;
  logic [31:0] wrData = 0, pktData = 0;
  logic [6:0] tblIdx = 0;
  logic [11:0] tblAddr = 0;
  logic [31:0] rdDataA, rdDataB, outWord, addrPortA, addrPortB;
  logic pktReady, rdStall, dispValid, dispBad, outValid;
  logic [11:0] dispAddr;
  logic [6:0] dispOpcode;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { logic isBad; logic [6:0] op; logic [11:0] addr; } dispExp_t;
  dispExp_t expQ[$];

  always #5 clk = ~clk;

  mcu_pkt_regfile u_dut (.*);

  function automatic logic [11:0] tblVal(input int i);
    return 12'((i * 37 + 5) & 'hfff);
  endfunction

  task automatic check(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(req, act === exp, act, exp);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    tick();
    wrEn = 0;
  endtask

  task automatic hdr(input logic [7:0] opField, input logic [13:0] cnt);
    dispExp_t e;
    e.isBad = opField[7];
    e.op    = opField[6:0];
    e.addr  = tblVal(int'(opField[6:0]));
    expQ.push_back(e);
    wr(5'h01, {8'h00, opField, 2'b00, cnt});
  endtask

  function automatic logic [31:0] peekA(input logic [4:0] a);
    rdAddrA = a;
    return 32'h0;
  endfunction

  task automatic readA(input logic [4:0] a, output logic [31:0] v);
    rdAddrA = a; #1; v = rdDataA;
  endtask

  // scoreboard monitor for dispatch results
  always @(negedge clk) begin
    if (rstN && (dispValid || dispBad)) begin
      if (expQ.size() == 0) begin
        check("R4 unexpected dispatch", 1'b0, {31'b0, dispValid}, 32'h0);
      end else begin
        dispExp_t e;
        e = expQ.pop_front();
        chk("R5 bad flag", {31'b0, dispBad}, {31'b0, e.isBad});
        chk("R4 valid flag", {31'b0, dispValid}, {31'b0, !e.isBad});
        if (!e.isBad) begin
          chk("R4 opcode", {25'b0, dispOpcode}, {25'b0, e.op});
          chk("R4 handler addr", {20'b0, dispAddr}, {20'b0, e.addr});
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) tick();
    rstN = 1;
    // reset state R11
    readA(5'h1c, v); chk("R11 count", v, 0);
    readA(5'h05, v); chk("R11 storage", v, 0);
    chk("R11 disp/out", {29'b0, dispValid, dispBad, outValid}, 0);
    // load jump table
    for (int i = 0; i < 128; i++) begin
      tblWe = 1; tblIdx = 7'(i); tblAddr = tblVal(i); tick();
    end
    tblWe = 0;
    // R2 store and read-during-write
    wr(5'h05, 32'hA5A5_0001);
    readA(5'h05, v); chk("R2 port A", v, 32'hA5A5_0001);
    rdAddrB = 5'h05; #1; chk("R2 port B", rdDataB, 32'hA5A5_0001);
    wrEn = 1; wrAddr = 5'h05; wrData = 32'h1234_5678; rdAddrA = 5'h05; #1;
    chk("R2 old value during write", rdDataA, 32'hA5A5_0001);
    tick(); wrEn = 0; #1;
    chk("R2 new value after write", rdDataA, 32'h1234_5678);
    // R1 zero register
    wr(5'h00, 32'hFFFF_FFFF);
    readA(5'h00, v); chk("R1 port A zero", v, 0);
    rdAddrB = 5'h00; #1; chk("R1 port B zero", rdDataB, 0);
    // R3/R4 header with opcode 3, count 5
    hdr(8'd3, 14'd5);
    readA(5'h1c, v); chk("R3 count load", v, 5);
    readA(5'h01, v); chk("R2 header readback", v, 32'h0003_0005);
    // R6 pop
    pktValid = 1; pktData = 32'hDEAD_0001; rdEnA = 1; rdAddrA = 5'h1f; #1;
    chk("R6 data returned", rdDataA, 32'hDEAD_0001);
    chk("R6 ready", {30'b0, pktReady, rdStall}, 32'h2);
    tick(); rdEnA = 0; readA(5'h1c, v); chk("R6 count decrement", v, 4);
    // R6 no pop without enable
    rdAddrA = 5'h1f; #1; chk("R6 no read enable no pop", {31'b0, pktReady}, 0);
    // R7 stall
    pktValid = 0; rdEnA = 1; #1;
    chk("R7 stall flags", {30'b0, pktReady, rdStall}, 32'h1);
    tick(); rdEnA = 0; readA(5'h1c, v); chk("R7 count unchanged", v, 4);
    // R8 dual read
    pktValid = 1; pktData = 32'hBEEF_0002; rdEnA = 1; rdEnB = 1; rdAddrA = 5'h1f; rdAddrB = 5'h1f; #1;
    chk("R8 port A", rdDataA, 32'hBEEF_0002);
    chk("R8 port B", rdDataB, 32'hBEEF_0002);
    tick(); rdEnA = 0; rdEnB = 0; pktValid = 0;
    readA(5'h1c, v); chk("R8 single pop", v, 3);
    // R4 top opcode, count 0 then saturation R6
    hdr(8'd127, 14'd0);
    pktValid = 1; rdEnA = 1; rdAddrA = 5'h1f; tick(); rdEnA = 0; pktValid = 0;
    readA(5'h1c, v); chk("R6 saturate at zero", v, 0);
    hdr(8'd0, 14'h3fff);
    readA(5'h1c, v); chk("R3 max count", v, 32'h3fff);
    // R5 out-of-range opcode
    hdr(8'h80, 14'd7);
    readA(5'h1c, v); chk("R5 count still loaded", v, 7);
    hdr(8'hC5, 14'd9);
    // R10 precedence
    pktValid = 1; rdEnA = 1; rdAddrA = 5'h1f;
    wr(5'h1c, 32'd2); rdEnA = 0; pktValid = 0;
    readA(5'h1c, v); chk("R10 count write beats pop", v, 2);
    pktValid = 1; rdEnA = 1; rdAddrA = 5'h1f;
    hdr(8'd10, 14'd6); rdEnA = 0; pktValid = 0;
    readA(5'h1c, v); chk("R10 header beats pop", v, 6);
    // R9 outgoing data and address ports
    wr(5'h1f, 32'hCAFE_F00D);
    chk("R9 out valid", {31'b0, outValid}, 1);
    chk("R9 out word", outWord, 32'hCAFE_F00D);
    tick(); chk("R9 out one cycle", {31'b0, outValid}, 0);
    wr(5'h1d, 32'h0000_1000); wr(5'h1e, 32'h0000_2000);
    chk("R9 address port A", addrPortA, 32'h0000_1000);
    chk("R9 address port B", addrPortB, 32'h0000_2000);
    repeat (3) tick();
    chk("R4 scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule